// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers interrupt requests from up to sixteen peripherals into a pending-status register and drives one level-sensitive interrupt line to the processor. A request pulse on any source line latches the matching pending bit. The bit stays set until software clears it. A mask register selects which pending bits may raise the processor line.

Software reaches both registers over a simple register bus. The bus carries a byte offset, a write strobe, a 32-bit write word and a 32-bit read word. Reads are combinational from the offset. To acknowledge, software writes the status register with a word that holds zero in each bit it wants to clear and one in each bit it wants to keep. The stored status becomes the old status ANDed with that word. Writing the mask replaces it outright. After every clock edge, the processor line shows whether any pending bit is also enabled. That holds after status writes, mask writes and new requests alike.

Top module: `irq_ctl_top`

## Requirements
- R1: A write to the status offset (0x70) stores old status AND the low 16 bits of the write word. A 0 bit clears the pending bit and a 1 bit keeps it. With no request active, a 1 bit never sets a clear bit.
- R2: A write to the mask offset (0x74) replaces all 16 mask bits with the low 16 bits of the write word.
- R3: `cpuIrq` is high exactly when (status AND mask) is nonzero. It is registered and follows the status and mask values stored at the same clock edge.
- R4: Any write to status or mask re-evaluates `cpuIrq` at that same edge. The line rises after a mask write that enables a pending bit. It falls after an acknowledge or mask write that leaves no enabled pending bit.
- R5: Reading offset 0x70 returns the status and reading 0x74 returns the mask, in the same cycle the offset is presented. Any other offset reads 0. A write to any other offset has no effect on status, mask or `cpuIrq`.
- R6: A high `srcReq[i]` on a clock edge sets status bit i. When an acknowledge write clears bit i on the same edge, the request wins and the bit stays set.
- R7: Bits 31:16 of `rdData` always read 0. Bits 31:16 of a write word have no effect.
- R8: While `rstN` is low, status and mask are cleared and `cpuIrq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| busAddr | input | 8 | Register byte offset |
| busWe | input | 1 | Write strobe, one write per cycle held high |
| busWdata | input | 32 | Write word |
| rdData | output | 32 | Read word for `busAddr` |
| srcReq | input | 16 | Peripheral request lines, one per status bit |
| cpuIrq | output | 1 | Level interrupt request to the processor |

## Verification
The bound checker watches several rules on every cycle after reset:
- the AND form of acknowledge;
- the mask overwrite;
- requests always landing in status, including against a same-edge acknowledge;
- the processor line matching status AND mask;
- the zero upper read half;
- status and mask staying put when no write and no request occur.

Other behaviour shows only in the bench's directed scenarios:
- that the line actually rises and falls across a given mask or acknowledge sequence;
- that writes to an unused offset leave both registers intact as seen by read-back;
- the reset values seen at the bus.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

  // Strobes handed from the decoder to the register datapath.
  typedef struct packed {
    logic statWr;
    logic maskWr;
  } ctlStrobe_t;

  // Which register drives the read word.
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_STAT = 2'd1,
    RD_MASK = 2'd2
  } rdSel_t;

endpackage

// File: rtl/irq_ctl_ctrl.sv
module irq_ctl_ctrl
  import irq_ctl_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h70,
  parameter logic [ADDR_W-1:0] MASK_OFS = 8'h74
) (
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output ctlStrobe_t        strobe,
  output rdSel_t            rdSel
);

  logic hitStat;
  logic hitMask;

  assign hitStat = (busAddr == STAT_OFS);
  assign hitMask = (busAddr == MASK_OFS);

  always_comb begin
    strobe        = '0;
    strobe.statWr = busWe && hitStat;
    strobe.maskWr = busWe && hitMask;
  end

  always_comb begin
    if (hitStat)      rdSel = RD_STAT;
    else if (hitMask) rdSel = RD_MASK;
    else              rdSel = RD_NONE;
  end

endmodule

// File: rtl/irq_ctl_dp.sv
module irq_ctl_dp
  import irq_ctl_pkg::*;
#(
  parameter int IRQ_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  rdSel_t            rdSel,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [IRQ_W-1:0]  srcReq,
  output logic [DATA_W-1:0] rdData,
  output logic [IRQ_W-1:0]  statusQ,
  output logic [IRQ_W-1:0]  maskQ,
  output logic              cpuIrq
);

  localparam int PAD_W = DATA_W - IRQ_W;

  logic [IRQ_W-1:0] wrLo;
  logic [IRQ_W-1:0] statusD;
  logic [IRQ_W-1:0] maskD;
  logic             irqD;
  logic             unusedHi;

  assign wrLo     = busWdata[IRQ_W-1:0];
  assign unusedHi = ^busWdata[DATA_W-1:IRQ_W];

  // Per-bit pending logic: acknowledge clears through AND, request sets last.
  for (genvar b = 0; b < IRQ_W; b++) begin : gBit
    assign statusD[b] = srcReq[b] | (statusQ[b] & ~(strobe.statWr & ~wrLo[b]));
  end

  assign maskD = strobe.maskWr ? wrLo : maskQ;
  assign irqD  = |(statusD & maskD);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '0;
      cpuIrq  <= 1'b0;
    end else begin
      statusQ <= statusD;
      maskQ   <= maskD;
      cpuIrq  <= irqD;
    end
  end

  always_comb begin
    unique case (rdSel)
      RD_STAT: rdData = {{PAD_W{1'b0}}, statusQ};
      RD_MASK: rdData = {{PAD_W{1'b0}}, maskQ};
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top
  import irq_ctl_pkg::*;
#(
  parameter int IRQ_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h70,
  parameter logic [ADDR_W-1:0] MASK_OFS = 8'h74
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] rdData,
  input  logic [IRQ_W-1:0]  srcReq,
  output logic              cpuIrq
);

  ctlStrobe_t       strobe;
  rdSel_t           rdSel;
  logic [IRQ_W-1:0] statusQ;
  logic [IRQ_W-1:0] maskQ;

  irq_ctl_ctrl #(
    .ADDR_W  (ADDR_W),
    .STAT_OFS(STAT_OFS),
    .MASK_OFS(MASK_OFS)
  ) ctrl_i (
    .busWe  (busWe),
    .busAddr(busAddr),
    .strobe (strobe),
    .rdSel  (rdSel)
  );

  irq_ctl_dp #(
    .IRQ_W (IRQ_W),
    .DATA_W(DATA_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .rdSel   (rdSel),
    .busWdata(busWdata),
    .srcReq  (srcReq),
    .rdData  (rdData),
    .statusQ (statusQ),
    .maskQ   (maskQ),
    .cpuIrq  (cpuIrq)
  );

endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk #(
  parameter int IRQ_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h70,
  parameter logic [ADDR_W-1:0] MASK_OFS = 8'h74
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] rdData,
  input logic [IRQ_W-1:0]  srcReq,
  input logic              cpuIrq,
  input logic [IRQ_W-1:0]  statusQ,
  input logic [IRQ_W-1:0]  maskQ
);

  logic live;
  always_ff @(posedge clk) begin
    if (!rstN) live <= 1'b0;
    else       live <= 1'b1;
  end

  logic stWr;
  logic mkWr;
  assign stWr = busWe && (busAddr == STAT_OFS);
  assign mkWr = busWe && (busAddr == MASK_OFS);

  AST_ACK_AND: assert property (@(posedge clk) disable iff (!rstN)
    (live && $past(stWr) && $past(srcReq) == '0)
      |-> statusQ == ($past(statusQ) & $past(busWdata[IRQ_W-1:0])));  // R1

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (live && $past(mkWr)) |-> maskQ == $past(busWdata[IRQ_W-1:0]));  // R2

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    live |-> cpuIrq == (|(statusQ & maskQ)));  // R3

  AST_REQ_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    live |-> ($past(srcReq) & ~statusQ) == '0);  // R6

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:IRQ_W] == '0);  // R7

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (live && !$past(busWe) && $past(srcReq) == '0)
      |-> ($stable(statusQ) && $stable(maskQ)));  // R5

endmodule

bind irq_ctl_top irq_ctl_chk #(
  .IRQ_W   (IRQ_W),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W),
  .STAT_OFS(STAT_OFS),
  .MASK_OFS(MASK_OFS)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .busAddr (busAddr),
  .busWe   (busWe),
  .busWdata(busWdata),
  .rdData  (rdData),
  .srcReq  (srcReq),
  .cpuIrq  (cpuIrq),
  .statusQ (statusQ),
  .maskQ   (maskQ)
);

// File: tb/irq_ctl_top_tb_top.sv
module irq_ctl_top_tb_top;

  localparam logic [7:0] A_STAT  = 8'h70;
  localparam logic [7:0] A_MASK  = 8'h74;
  localparam logic [7:0] A_OTHER = 8'h78;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  busAddr;
  logic        busWe;
  logic [31:0] busWdata;
  logic [31:0] rdData;
  logic [15:0] srcReq;
  logic        cpuIrq;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  irq_ctl_top dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .rdData(rdData), .srcReq(srcReq), .cpuIrq(cpuIrq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One edge: drive at negedge, let posedge act, return at next negedge.
  task automatic cycle(input logic we, input logic [7:0] a, input logic [31:0] d,
                       input logic [15:0] req);
    busWe = we; busAddr = a; busWdata = d; srcReq = req;
    @(negedge clk);
    busWe = 1'b0; srcReq = '0;
  endtask

  task automatic readReg(input logic [7:0] a, output logic [31:0] v);
    busAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic tReset();
    logic [31:0] v;
    rstN = 1'b0;
    repeat (2) cycle(1'b0, A_STAT, 32'h0, 16'hFFFF);
    rstN = 1'b1;
    readReg(A_STAT, v); check("R8 status", v, 32'h0);
    readReg(A_MASK, v); check("R8 mask", v, 32'h0);
    check("R8 cpuIrq", {31'h0, cpuIrq}, 32'h0);
  endtask

  task automatic tRequest();
    logic [31:0] v;
    cycle(1'b0, A_OTHER, 32'h0, 16'h0009);
    cycle(1'b0, A_OTHER, 32'h0, 16'h0000);
    readReg(A_STAT, v); check("R6 latched", v, 32'h0000_0009);
    check("R3 masked off", {31'h0, cpuIrq}, 32'h0);
  endtask

  task automatic tMask();
    logic [31:0] v;
    cycle(1'b1, A_MASK, 32'h0000_0008, 16'h0);
    readReg(A_MASK, v); check("R2 mask load", v, 32'h0000_0008);
    check("R4 rise on mask", {31'h0, cpuIrq}, 32'h1);
    cycle(1'b1, A_MASK, 32'hFFFF_0002, 16'h0);
    readReg(A_MASK, v); check("R7 upper ignored", v, 32'h0000_0002);
    check("R4 fall on mask", {31'h0, cpuIrq}, 32'h0);
  endtask

  task automatic tAck();
    logic [31:0] v;
    cycle(1'b1, A_STAT, 32'h0000_FFFE, 16'h0);
    readReg(A_STAT, v); check("R1 and-ack", v, 32'h0000_0008);
    cycle(1'b1, A_MASK, 32'h0000_0008, 16'h0);
    check("R3 enabled", {31'h0, cpuIrq}, 32'h1);
    cycle(1'b1, A_STAT, 32'h0000_FFF7, 16'h0008);
    readReg(A_STAT, v); check("R6 request wins", v, 32'h0000_0008);
    check("R6 irq kept", {31'h0, cpuIrq}, 32'h1);
    cycle(1'b1, A_STAT, 32'hFFFF_FFF7, 16'h0);
    readReg(A_STAT, v); check("R1 clear", v, 32'h0);
    check("R4 fall on ack", {31'h0, cpuIrq}, 32'h0);
    cycle(1'b1, A_STAT, 32'hFFFF_FFFF, 16'h0);
    readReg(A_STAT, v); check("R1 ones keep clear", v, 32'h0);
  endtask

  task automatic tOther();
    logic [31:0] v;
    cycle(1'b0, A_OTHER, 32'h0, 16'h0108);
    cycle(1'b1, A_OTHER, 32'h0000_0000, 16'h0);
    readReg(A_STAT, v); check("R5 status kept", v, 32'h0000_0108);
    readReg(A_MASK, v); check("R5 mask kept", v, 32'h0000_0008);
    check("R5 irq kept", {31'h0, cpuIrq}, 32'h1);
    readReg(A_OTHER, v); check("R5 other reads 0", v, 32'h0);
    readReg(A_STAT, v); check("R7 upper read 0", {16'h0, v[31:16]}, 32'h0);
  endtask

  initial begin
    busWe = 1'b0; busAddr = '0; busWdata = '0; srcReq = '0; rstN = 1'b0;
    @(negedge clk);
    tReset();
    tRequest();
    tMask();
    tAck();
    tOther();
    tReset();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule